// File: doc/BRIEF.md
# Machine-Mode Control Register Unit with Trap Capture

This unit holds the machine-level control state of a small 32-bit core. It runs the six read-modify-write control-register instructions against nine registers: status, interrupt enable, interrupt pending, trap vector, trap cause, faulting value, exception PC, scratch and ISA descriptor. In the cycle of a request it returns the register's previous contents. Any address outside the nine, and any function code that is not a control-register operation, is reported on `csr_illegal`. The pipeline then raises an illegal-instruction exception, keeps the destination register unwritten and holds the PC.

The pipeline also presents trap requests. Each request carries a cause code, an interrupt flag, the PC of the trapping instruction, and a faulting value that is only sometimes present. On a trap the unit records the cause and the return PC and saves the interrupt-enable bit before clearing it. It updates the faulting-value register only when the request says a value is present. The handler address is always on `trap_target`.

The instruction port is a valid/ready stream. A request is accepted on a rising edge where `csr_valid` and `csr_ready` are both high. `csr_ready` falls in any cycle that carries a trap, because the trap takes priority. A request that is not accepted has no effect on state, and the pipeline must hold it until it is accepted. Read data and the illegal flag are combinational and valid whenever `csr_valid` is high.

Top module: `mcsr_unit`

## Requirements
- R1: After reset the status register reads 0x00001800 (previous-privilege field bits 12:11 = 3, enable bit 3 = 0, saved-enable bit 7 = 0). Cause, faulting value, exception PC and the ISA register all read zero.
- R2: `csr_rdata` carries the addressed register's value from before the request, in the same cycle that `csr_valid` is high.
- R3: Write forms (funct3 bits 1:0 = 01) replace the register with the operand.
- R4: Set forms (bits 1:0 = 10) store old OR operand. Clear forms (bits 1:0 = 11) store old AND NOT operand.
- R5: Set and clear forms whose 5-bit rs1 field is zero leave the register unchanged and still return the old value.
- R6: When funct3 bit 2 is 1, the operand is the rs1 field zero-extended. When it is 0, the operand is `csr_src`.
- R7: An address outside {0x300 status, 0x301 ISA, 0x304 enable, 0x305 vector, 0x340 scratch, 0x341 exception PC, 0x342 cause, 0x343 faulting value, 0x344 pending}, or funct3 bits 1:0 = 00, drives `csr_illegal` high and `csr_rdata` to zero, and changes no state.
- R8: An accepted trap sets cause to {interrupt flag in bit 31, code in the low bits}. It loads the exception PC with `trap_pc`, copies the enable bit into the saved-enable bit, and clears the enable bit.
- R9: The faulting-value register takes `trap_value` only when `trap_has_value` is high. Otherwise it keeps its contents.
- R10: With `trap_valid` high, `csr_ready` is low, and a CSR request in that cycle writes nothing.
- R11: Bits 1:0 of the trap vector always read zero, and `trap_target` equals the trap vector register.
- R12: The ISA register ignores writes and reads zero. The status previous-privilege field always reads 3, and writes reach only bits 3 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | CSR request present |
| csr_ready | output | 1 | Request accepted this cycle (low during a trap) |
| csr_addr | input | 12 | Register address |
| csr_funct3 | input | 3 | Operation code |
| csr_rs1_idx | input | 5 | rs1 field; immediate operand for bit-2 forms |
| csr_src | input | 32 | Register-sourced operand |
| csr_rdata | output | 32 | Previous register value |
| csr_illegal | output | 1 | Request is an illegal instruction |
| trap_valid | input | 1 | Trap request |
| trap_is_irq | input | 1 | Trap is an interrupt |
| trap_code | input | 5 | Exception code |
| trap_has_value | input | 1 | `trap_value` must be recorded |
| trap_value | input | 32 | Faulting address or target |
| trap_pc | input | 32 | PC of trapping instruction |
| trap_target | output | 32 | Handler address |

## Verification
The assertions run on every cycle. They check the trap side effects on the exception PC and the enable bit, the retention of the faulting value when a trap carries none, zero read data on illegal requests, the privilege field on status reads, and the absence of scratch updates on zero-rs1 set/clear forms and under a colliding trap. Only the bench's scenarios can show the arithmetic of each read-modify-write form, the immediate operand selection, the reset values, the vector alignment and the cause encoding, because each needs a chain of writes followed by read-back.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int ADDR_W  = 12;
  localparam int NUM_CSR = 9;

  typedef enum logic [3:0] {
    S_STATUS, S_ISA, S_IE, S_TVEC, S_SCRATCH, S_EPC, S_CAUSE, S_BAD, S_IP
  } csr_sel_e;

  localparam logic [ADDR_W-1:0] A_STATUS  = 12'h300;
  localparam logic [ADDR_W-1:0] A_ISA     = 12'h301;
  localparam logic [ADDR_W-1:0] A_IE      = 12'h304;
  localparam logic [ADDR_W-1:0] A_TVEC    = 12'h305;
  localparam logic [ADDR_W-1:0] A_SCRATCH = 12'h340;
  localparam logic [ADDR_W-1:0] A_EPC     = 12'h341;
  localparam logic [ADDR_W-1:0] A_CAUSE   = 12'h342;
  localparam logic [ADDR_W-1:0] A_BAD     = 12'h343;
  localparam logic [ADDR_W-1:0] A_IP      = 12'h344;

  // index order follows csr_sel_e
  localparam logic [ADDR_W-1:0] CSR_ADDR [NUM_CSR] = '{
    A_STATUS, A_ISA, A_IE, A_TVEC, A_SCRATCH, A_EPC, A_CAUSE, A_BAD, A_IP
  };

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  localparam int ST_IE_BIT   = 3;
  localparam int ST_PIE_BIT  = 7;
  localparam int ST_PRIV_LO  = 11;
  localparam int IMM_W       = 5;
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_CSR-1:0] sel,
  output logic               hit
);
  for (genvar g = 0; g < NUM_CSR; g++) begin : g_match
    assign sel[g] = (addr == CSR_ADDR[g]);
  end
  assign hit = |sel;
endmodule

// File: rtl/mcsr_rmw.sv
module mcsr_rmw
  import mcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]       funct3,
  input  logic [IMM_W-1:0] rs1_idx,
  input  logic [XLEN-1:0]  src,
  input  logic [XLEN-1:0]  old,
  output logic [XLEN-1:0]  wdata,
  output logic             wr_req,
  output logic             op_ok
);
  csr_op_e         op;
  logic [XLEN-1:0] operand;
  logic [XLEN-1:0] set_m;
  logic [XLEN-1:0] clr_m;

  always_comb begin
    op      = csr_op_e'(funct3[1:0]);
    operand = funct3[2] ? {{(XLEN-IMM_W){1'b0}}, rs1_idx} : src;
    set_m   = '0;
    clr_m   = '0;
    wr_req  = 1'b0;
    op_ok   = 1'b1;
    case (op)
      OP_WRITE: begin clr_m = '1; set_m = operand; wr_req = 1'b1; end
      OP_SET:   begin set_m = operand; wr_req = (rs1_idx != '0); end
      OP_CLEAR: begin clr_m = operand; wr_req = (rs1_idx != '0); end
      default:  op_ok = 1'b0;
    endcase
    wdata = (old & ~clr_m) | set_m;
  end
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_valid,
  output logic              csr_ready,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [2:0]        csr_funct3,
  input  logic [IMM_W-1:0]  csr_rs1_idx,
  input  logic [XLEN-1:0]   csr_src,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  input  logic              trap_valid,
  input  logic              trap_is_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic              trap_has_value,
  input  logic [XLEN-1:0]   trap_value,
  input  logic [XLEN-1:0]   trap_pc,
  output logic [XLEN-1:0]   trap_target
);
  localparam int PAD_W = XLEN - 1 - CODE_W;

  logic [NUM_CSR-1:0] sel;
  logic               hit;
  logic [XLEN-1:0]    old_val;
  logic [XLEN-1:0]    wdata;
  logic               wr_req;
  logic               op_ok;
  logic               do_write;

  logic            st_ie, st_pie;
  logic [XLEN-1:0] ie_q, ip_q, tvec_q, scratch_q, epc_q, cause_q, bad_q;
  logic [XLEN-1:0] status_rd;
  logic [XLEN-1:0] rd_vec [NUM_CSR];

  mcsr_decode u_dec (
    .addr (csr_addr),
    .sel  (sel),
    .hit  (hit)
  );

  mcsr_rmw #(.XLEN(XLEN)) u_rmw (
    .funct3  (csr_funct3),
    .rs1_idx (csr_rs1_idx),
    .src     (csr_src),
    .old     (old_val),
    .wdata   (wdata),
    .wr_req  (wr_req),
    .op_ok   (op_ok)
  );

  always_comb begin
    status_rd                           = '0;
    status_rd[ST_IE_BIT]                = st_ie;
    status_rd[ST_PIE_BIT]               = st_pie;
    status_rd[ST_PRIV_LO+1:ST_PRIV_LO]  = 2'b11;
  end

  assign rd_vec[S_STATUS]  = status_rd;
  assign rd_vec[S_ISA]     = '0;
  assign rd_vec[S_IE]      = ie_q;
  assign rd_vec[S_TVEC]    = tvec_q;
  assign rd_vec[S_SCRATCH] = scratch_q;
  assign rd_vec[S_EPC]     = epc_q;
  assign rd_vec[S_CAUSE]   = cause_q;
  assign rd_vec[S_BAD]     = bad_q;
  assign rd_vec[S_IP]      = ip_q;

  always_comb begin
    old_val = '0;
    for (int i = 0; i < NUM_CSR; i++) begin
      if (sel[i]) old_val = old_val | rd_vec[i];
    end
  end

  assign csr_ready   = !trap_valid;
  assign csr_illegal = csr_valid && (!hit || !op_ok);
  assign csr_rdata   = (csr_valid && !csr_illegal) ? old_val : '0;
  assign do_write    = csr_valid && csr_ready && !csr_illegal && wr_req;
  assign trap_target = tvec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_ie     <= 1'b0;
      st_pie    <= 1'b0;
      ie_q      <= '0;
      ip_q      <= '0;
      tvec_q    <= '0;
      scratch_q <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
      bad_q     <= '0;
    end else if (trap_valid) begin
      cause_q <= {trap_is_irq, {PAD_W{1'b0}}, trap_code};
      epc_q   <= trap_pc;
      st_pie  <= st_ie;
      st_ie   <= 1'b0;
      if (trap_has_value) bad_q <= trap_value;
    end else if (do_write) begin
      if (sel[S_STATUS]) begin
        st_ie  <= wdata[ST_IE_BIT];
        st_pie <= wdata[ST_PIE_BIT];
      end
      if (sel[S_IE])      ie_q      <= wdata;
      if (sel[S_IP])      ip_q      <= wdata;
      if (sel[S_TVEC])    tvec_q    <= {wdata[XLEN-1:2], 2'b00};
      if (sel[S_SCRATCH]) scratch_q <= wdata;
      if (sel[S_EPC])     epc_q     <= wdata;
      if (sel[S_CAUSE])   cause_q   <= wdata;
      if (sel[S_BAD])     bad_q     <= wdata;
    end
  end
endmodule

// File: rtl/mcsr_checker.sv
module mcsr_checker
  import mcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_valid,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [2:0]        csr_funct3,
  input logic [IMM_W-1:0]  csr_rs1_idx,
  input logic              csr_illegal,
  input logic [XLEN-1:0]   csr_rdata,
  input logic              trap_valid,
  input logic              trap_has_value,
  input logic [XLEN-1:0]   trap_pc,
  input logic              st_ie,
  input logic [XLEN-1:0]   epc_q,
  input logic [XLEN-1:0]   bad_q,
  input logic [XLEN-1:0]   scratch_q
);
  AST_TRAP_EPC: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> epc_q == $past(trap_pc)); // R8
  AST_TRAP_IE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> !st_ie); // R8
  AST_BAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !trap_has_value) |=> $stable(bad_q)); // R9
  AST_ILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_rdata == '0); // R7
  AST_PRIV_M: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && !csr_illegal && csr_addr == A_STATUS) |-> csr_rdata[12:11] == 2'b11); // R12
  AST_ZERO_RS1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && csr_addr == A_SCRATCH && csr_funct3[1] && csr_rs1_idx == '0)
      |=> $stable(scratch_q)); // R5
  AST_TRAP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && csr_valid && csr_addr == A_SCRATCH) |=> $stable(scratch_q)); // R10
endmodule

bind mcsr_unit mcsr_checker #(.XLEN(XLEN)) u_mcsr_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .csr_valid      (csr_valid),
  .csr_addr       (csr_addr),
  .csr_funct3     (csr_funct3),
  .csr_rs1_idx    (csr_rs1_idx),
  .csr_illegal    (csr_illegal),
  .csr_rdata      (csr_rdata),
  .trap_valid     (trap_valid),
  .trap_has_value (trap_has_value),
  .trap_pc        (trap_pc),
  .st_ie          (st_ie),
  .epc_q          (epc_q),
  .bad_q          (bad_q),
  .scratch_q      (scratch_q)
);

// File: tb/test_mcsr_unit.sv
module test_mcsr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_valid;
  logic        csr_ready;
  logic [11:0] csr_addr;
  logic [2:0]  csr_funct3;
  logic [4:0]  csr_rs1_idx;
  logic [31:0] csr_src;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  logic        trap_valid;
  logic        trap_is_irq;
  logic [4:0]  trap_code;
  logic        trap_has_value;
  logic [31:0] trap_value;
  logic [31:0] trap_pc;
  logic [31:0] trap_target;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mcsr_unit i_mcsr_unit (
    .clk(clk), .rst_n(rst_n),
    .csr_valid(csr_valid), .csr_ready(csr_ready),
    .csr_addr(csr_addr), .csr_funct3(csr_funct3), .csr_rs1_idx(csr_rs1_idx),
    .csr_src(csr_src), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .trap_valid(trap_valid), .trap_is_irq(trap_is_irq), .trap_code(trap_code),
    .trap_has_value(trap_has_value), .trap_value(trap_value), .trap_pc(trap_pc),
    .trap_target(trap_target)
  );

  typedef struct packed {
    logic [11:0] addr;
    logic [2:0]  f3;
    logic [4:0]  rs1;
    logic [31:0] src;
    logic [31:0] exp;
    logic        ill;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{12'h340, 3'b001, 5'd1,  32'hA5A5A5A5, 32'h00000000, 1'b0, 4'd3},  // R3
    '{12'h340, 3'b010, 5'd1,  32'h0000FFFF, 32'hA5A5A5A5, 1'b0, 4'd4},  // R4
    '{12'h340, 3'b011, 5'd1,  32'hA5A50000, 32'hA5A5FFFF, 1'b0, 4'd4},  // R4
    '{12'h340, 3'b010, 5'd0,  32'hFFFFFFFF, 32'h0000FFFF, 1'b0, 4'd5},  // R5
    '{12'h340, 3'b011, 5'd0,  32'hFFFFFFFF, 32'h0000FFFF, 1'b0, 4'd5},  // R5
    '{12'h340, 3'b101, 5'h15, 32'hDEADBEEF, 32'h0000FFFF, 1'b0, 4'd6},  // R6
    '{12'h340, 3'b110, 5'h0A, 32'hFFFFFFFF, 32'h00000015, 1'b0, 4'd6},  // R6
    '{12'h340, 3'b111, 5'h03, 32'h00000000, 32'h0000001F, 1'b0, 4'd6},  // R6
    '{12'h340, 3'b010, 5'd0,  32'h00000000, 32'h0000001C, 1'b0, 4'd6},  // R6
    '{12'h301, 3'b001, 5'd1,  32'hFFFFFFFF, 32'h00000000, 1'b0, 4'd12}, // R12
    '{12'h301, 3'b010, 5'd0,  32'h00000000, 32'h00000000, 1'b0, 4'd12}, // R12
    '{12'h305, 3'b001, 5'd1,  32'h80000103, 32'h00000000, 1'b0, 4'd11}, // R11
    '{12'h305, 3'b010, 5'd0,  32'h00000000, 32'h80000100, 1'b0, 4'd11}, // R11
    '{12'h7C0, 3'b001, 5'd1,  32'h00000001, 32'h00000000, 1'b1, 4'd7},  // R7
    '{12'h340, 3'b000, 5'd1,  32'hFFFFFFFF, 32'h00000000, 1'b1, 4'd7},  // R7
    '{12'h340, 3'b100, 5'd1,  32'hFFFFFFFF, 32'h00000000, 1'b1, 4'd7},  // R7
    '{12'h340, 3'b010, 5'd0,  32'h00000000, 32'h0000001C, 1'b0, 4'd7},  // R7
    '{12'h300, 3'b001, 5'd1,  32'hFFFFFFFF, 32'h00001800, 1'b0, 4'd12}, // R12
    '{12'h300, 3'b010, 5'd0,  32'h00000000, 32'h00001888, 1'b0, 4'd12}, // R12
    '{12'h300, 3'b011, 5'd1,  32'h00000080, 32'h00001888, 1'b0, 4'd4},  // R4
    '{12'h300, 3'b010, 5'd0,  32'h00000000, 32'h00001808, 1'b0, 4'd2}   // R2
  };

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic csr_req(input logic [11:0] a, input logic [2:0] f3, input logic [4:0] r,
                         input logic [31:0] s, input logic [31:0] exp, input logic ill,
                         input string rq);
    @(negedge clk);
    csr_valid = 1'b1; csr_addr = a; csr_funct3 = f3; csr_rs1_idx = r; csr_src = s;
    #1;
    check(csr_rdata === exp, rq, csr_rdata, exp);
    check(csr_illegal === ill, rq, {31'b0, csr_illegal}, {31'b0, ill});
    @(posedge clk);
    #1 csr_valid = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string rq);
    csr_req(a, 3'b010, 5'd0, 32'h0, exp, 1'b0, rq);
  endtask

  task automatic trap(input logic irq, input logic [4:0] code, input logic hv,
                      input logic [31:0] val, input logic [31:0] pc, input logic with_csr);
    @(negedge clk);
    trap_valid = 1'b1; trap_is_irq = irq; trap_code = code;
    trap_has_value = hv; trap_value = val; trap_pc = pc;
    if (with_csr) begin
      csr_valid = 1'b1; csr_addr = 12'h340; csr_funct3 = 3'b001;
      csr_rs1_idx = 5'd1; csr_src = 32'h12345678;
    end
    #1;
    check(trap_target === 32'h80000100, "R11", trap_target, 32'h80000100);
    check(csr_ready === 1'b0, "R10", {31'b0, csr_ready}, 32'h0);
    @(posedge clk);
    #1 trap_valid = 1'b0; csr_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    rst_n = 1'b0; csr_valid = 1'b0; csr_addr = '0; csr_funct3 = '0;
    csr_rs1_idx = '0; csr_src = '0; trap_valid = 1'b0; trap_is_irq = 1'b0;
    trap_code = '0; trap_has_value = 1'b0; trap_value = '0; trap_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    check(csr_ready === 1'b1, "R10", {31'b0, csr_ready}, 32'h1);
    rd(12'h300, 32'h00001800, "R1");
    rd(12'h342, 32'h00000000, "R1");
    rd(12'h343, 32'h00000000, "R1");
    rd(12'h341, 32'h00000000, "R1");
    rd(12'h301, 32'h00000000, "R1");

    for (int i = 0; i < NV; i++) begin
      csr_req(VECS[i].addr, VECS[i].f3, VECS[i].rs1, VECS[i].src, VECS[i].exp,
              VECS[i].ill, $sformatf("R%0d", VECS[i].rq));
    end

    // R8 R9: exception with value while enable bit is set
    trap(1'b0, 5'd4, 1'b1, 32'h00001003, 32'h00000200, 1'b0);
    rd(12'h342, 32'h00000004, "R8");
    rd(12'h341, 32'h00000200, "R8");
    rd(12'h343, 32'h00001003, "R9");
    rd(12'h300, 32'h00001880, "R8");

    // R8 R9: interrupt without value
    trap(1'b1, 5'd5, 1'b0, 32'hFFFFFFFF, 32'h00000300, 1'b0);
    rd(12'h342, 32'h80000005, "R8");
    rd(12'h343, 32'h00001003, "R9");
    rd(12'h300, 32'h00001800, "R8");

    // R10: trap collides with a scratch write
    trap(1'b0, 5'd0, 1'b1, 32'h00000055, 32'h00000400, 1'b1);
    rd(12'h340, 32'h0000001C, "R10");
    rd(12'h343, 32'h00000055, "R9");
    rd(12'h342, 32'h00000000, "R8");
    rd(12'h341, 32'h00000400, "R8");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule